// File: doc/BRIEF.md
# SPI Board Resource Register File

This block is an SPI slave that gives an external host access to a small set of board-management registers. The host uses SPI mode 3: the clock idles high, bits are sampled on the rising edge and sent most significant bit first. Every transaction is two bytes long. The first byte is a command: its upper seven bits hold an even register address and bit 0 selects the direction. The second byte carries the data. On a read, the block drives that byte on MISO. On a write, the block takes it from MOSI.

The register file holds a version constant and an LED register. It samples eight push-button and DIP-switch inputs and keeps a sticky change flag for each of them, and it raises an interrupt while any flag is set. It also shows three power-good input bytes and an I2C master select input byte. Eight control bytes drive enables and resets on the board. SCK, MOSI, CS_n and every status input pass through two-flop synchronizers into the system clock domain. The SPI pins are oversampled there and never used as clocks.

Top module: `spi_board_regs`

## Requirements
- R1: Framing follows SPI mode 3, most significant bit first. MOSI is sampled on rising SCK edges. MISO changes only after falling SCK edges. It is 0 while CS_n is high and throughout the command byte, and it carries the read data during the second byte.
- R2: In the command byte, bit 0 = 1 means read and bit 0 = 0 means write. The register address is the command with bit 0 cleared (0x00 to 0x1E). Address 0x00 reads as the VERSION parameter (default 0x13).
- R3: For the LED register at 0x02, only data bits 7:4 are stored, and they drive led_o[3:0]. Bits 3:0 read back as 0.
- R4: The registers at 0x00 (version), 0x04 (button/switch input), 0x08, 0x0A and 0x0C (power-good 1, 2, 3) and 0x18 (I2C master select input) are read-only, and writes to them have no effect.
- R5: The control registers and their outputs are 0x0E pwr_en_o, 0x10 cpu_rst_o, 0x12 usb_rst_o, 0x14 sfpa_o, 0x16 sfpb_o, 0x1A warm_rst_o, 0x1C warm_key_o and 0x1E pmbus_o. Each clears to 0 at reset, takes the written byte and reads back that byte.
- R6: Reads of input-backed registers return the live synchronized input value at the end of the command byte. Nothing is cached.
- R7: In the flag register at 0x06, bit k is set on any edge (rise or fall) of the synchronized btn_i[k]. The bit stays set until a write with bit k = 1. Bits written as 0 are untouched, and a new edge wins over a clear in the same cycle.
- R8: irq_o is high exactly while at least one flag bit is set, and it is 0 after reset.
- R9: If CS_n rises before the sixteenth rising SCK edge of a transaction, no register is written. The next transaction starts cleanly.
- R10: Commands with address bits 7:5 not all zero (addresses above 0x1E) read as 0x00, and writing to them changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI clock from host, idles high |
| mosi_i | input | 1 | SPI data from host |
| csn_i | input | 1 | SPI chip select, active low |
| miso_o | output | 1 | SPI data to host |
| btn_i | input | 8 | Push-button and DIP-switch levels |
| pg1_i | input | 8 | Power-good group 1 |
| pg2_i | input | 8 | Power-good group 2 |
| pg3_i | input | 8 | Power-good group 3 |
| i2c_sel_i | input | 8 | I2C master select status |
| led_o | output | 4 | LED drive (register bits 7:4) |
| pwr_en_o | output | 8 | Mezzanine and PCIe power enables |
| cpu_rst_o | output | 8 | Processor reset controls |
| usb_rst_o | output | 8 | USB and flash reset controls |
| sfpa_o | output | 8 | Optical module A control |
| sfpb_o | output | 8 | Optical module B control |
| warm_rst_o | output | 8 | Warm reset control |
| warm_key_o | output | 8 | Warm reset key |
| pmbus_o | output | 8 | Power-management bus control |
| irq_o | output | 1 | High while any change flag is set |

## Verification
The bench aims at the LED nibble mask, at writes to read-only and out-of-range addresses, and at a transaction cut short by CS_n. A design that got these wrong would show stray LED bits on readback, a changed input register, or a register written by a half-sent byte. It also toggles a button both ways while its flag is already set, clears with a zero mask and then with a one mask, and reads power-good right after an input change. A broken design would then lose or fail to clear a flag, misdrive irq_o, or return a stale cached value. Every read is checked bit by bit on MISO, so a shifter that loads late or shifts one bit off shows up as a wrong byte.

// File: rtl/spi_board_regs.sv
module spi_board_regs #(
  parameter logic [7:0] VERSION = 8'h13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic       csn_i,
  output logic       miso_o,
  input  logic [7:0] btn_i,
  input  logic [7:0] pg1_i,
  input  logic [7:0] pg2_i,
  input  logic [7:0] pg3_i,
  input  logic [7:0] i2c_sel_i,
  output logic [3:0] led_o,
  output logic [7:0] pwr_en_o,
  output logic [7:0] cpu_rst_o,
  output logic [7:0] usb_rst_o,
  output logic [7:0] sfpa_o,
  output logic [7:0] sfpb_o,
  output logic [7:0] warm_rst_o,
  output logic [7:0] warm_key_o,
  output logic [7:0] pmbus_o,
  output logic       irq_o
);

  localparam int NREG = 16;
  localparam int IW   = $clog2(NREG);
  localparam logic [NREG-1:0] WR_MASK = 16'b1110_1111_1000_0010;
  localparam logic [IW-1:0] IDX_LED  = 4'd1;
  localparam logic [IW-1:0] IDX_FLAG = 4'd3;

  logic [2:0] sck_s;
  logic [1:0] mosi_s, csn_s;
  logic [7:0] btn_m, btn_s, btn_q;
  logic [7:0] pg1_m, pg1_s, pg2_m, pg2_s, pg3_m, pg3_s, i2c_m, i2c_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= 3'b111;
      mosi_s <= 2'b00;
      csn_s  <= 2'b11;
      btn_m  <= '0; btn_s <= '0; btn_q <= '0;
      pg1_m  <= '0; pg1_s <= '0;
      pg2_m  <= '0; pg2_s <= '0;
      pg3_m  <= '0; pg3_s <= '0;
      i2c_m  <= '0; i2c_s <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      mosi_s <= {mosi_s[0], mosi_i};
      csn_s  <= {csn_s[0], csn_i};
      btn_m  <= btn_i;     btn_s <= btn_m;  btn_q <= btn_s;
      pg1_m  <= pg1_i;     pg1_s <= pg1_m;
      pg2_m  <= pg2_i;     pg2_s <= pg2_m;
      pg3_m  <= pg3_i;     pg3_s <= pg3_m;
      i2c_m  <= i2c_sel_i; i2c_s <= i2c_m;
    end
  end

  logic sck_rise, sck_fall, active;
  assign sck_rise = sck_s[1] & ~sck_s[2];
  assign sck_fall = ~sck_s[1] & sck_s[2];
  assign active   = ~csn_s[1];

  logic [2:0] bit_cnt;
  logic       in_data, done;
  logic [7:0] cmd_q, hold_q, tx_q;
  logic [6:0] rx_q;
  logic [7:0] rx_next;
  assign rx_next = {rx_q, mosi_s[1]};

  logic [7:0] rf_q [NREG];
  logic [7:0] flag_q;
  logic [7:0] rd_val;

  always_comb begin
    rd_val = 8'h00;
    if (rx_next[0] && rx_next[7:5] == 3'b000) begin
      case (rx_next[4:1])
        4'd0:    rd_val = VERSION;
        4'd2:    rd_val = btn_s;
        4'd3:    rd_val = flag_q;
        4'd4:    rd_val = pg1_s;
        4'd5:    rd_val = pg2_s;
        4'd6:    rd_val = pg3_s;
        4'd12:   rd_val = i2c_s;
        default: rd_val = rf_q[rx_next[4:1]];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      in_data <= 1'b0;
      done    <= 1'b0;
      cmd_q   <= '0;
      hold_q  <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else if (!active) begin
      bit_cnt <= '0;
      in_data <= 1'b0;
      done    <= 1'b0;
      tx_q    <= '0;
    end else begin
      if (sck_rise && !done) begin
        rx_q    <= rx_next[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (!in_data) begin
            cmd_q   <= rx_next;
            hold_q  <= rd_val;
            in_data <= 1'b1;
          end else begin
            done <= 1'b1;
          end
        end
      end
      if (sck_fall && in_data && !done)
        tx_q <= (bit_cnt == 3'd0) ? hold_q : {tx_q[6:0], 1'b0};
    end
  end

  assign miso_o = tx_q[7];

  logic          wr_fire;
  logic [IW-1:0] wr_idx;
  assign wr_fire = active && sck_rise && !done && in_data && bit_cnt == 3'd7 &&
                   !cmd_q[0] && cmd_q[7:5] == 3'b000;
  assign wr_idx  = cmd_q[4:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else if (wr_fire && WR_MASK[wr_idx]) begin
      rf_q[wr_idx] <= (wr_idx == IDX_LED) ? {rx_next[7:4], 4'b0000} : rx_next;
    end
  end

  logic [7:0] flag_clr, flag_set;
  assign flag_clr = (wr_fire && wr_idx == IDX_FLAG) ? rx_next : 8'h00;
  assign flag_set = btn_s ^ btn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  assign irq_o      = |flag_q;
  assign led_o      = rf_q[1][7:4];
  assign pwr_en_o   = rf_q[7];
  assign cpu_rst_o  = rf_q[8];
  assign usb_rst_o  = rf_q[9];
  assign sfpa_o     = rf_q[10];
  assign sfpb_o     = rf_q[11];
  assign warm_rst_o = rf_q[13];
  assign warm_key_o = rf_q[14];
  assign pmbus_o    = rf_q[15];

  assert_miso_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && active) |=> $stable(miso_o));

  assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> ($stable(led_o) && $stable(pwr_en_o) && $stable(cpu_rst_o) &&
                 $stable(warm_rst_o) && $stable(pmbus_o)));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr == 8'h00) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == 8'h00 && btn_s == btn_q) |=> !irq_o);

endmodule

// File: tb/test_spi_board_regs.sv
module test_spi_board_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1, mosi = 1'b0, csn = 1'b1;
  logic miso;
  logic [7:0] btn = 8'h00, pg1 = 8'h3C, pg2 = 8'hC3, pg3 = 8'h5A, i2c = 8'h81;
  logic [3:0] led;
  logic [7:0] pwr_en, cpu_rst, usb_rst, sfpa, sfpb, warm_rst, warm_key, pmbus;
  logic irq;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  spi_board_regs i_spi_board_regs (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .csn_i(csn),
    .miso_o(miso), .btn_i(btn), .pg1_i(pg1), .pg2_i(pg2), .pg3_i(pg3),
    .i2c_sel_i(i2c), .led_o(led), .pwr_en_o(pwr_en), .cpu_rst_o(cpu_rst),
    .usb_rst_o(usb_rst), .sfpa_o(sfpa), .sfpb_o(sfpb), .warm_rst_o(warm_rst),
    .warm_key_o(warm_key), .pmbus_o(pmbus), .irq_o(irq));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits < 16 aborts by raising CS_n early
  task automatic xfer(input logic [7:0] cmd, input logic [7:0] wd, input int nbits,
                      input bit check, input logic [7:0] exp, input string tag);
    logic [15:0] frame;
    logic [7:0]  rx;
    frame = {cmd, wd};
    rx = 8'h00;
    csn = 1'b0;
    wait_clk(6);
    for (int b = 0; b < nbits; b++) begin
      sck = 1'b0;
      mosi = frame[15-b];
      wait_clk(8);
      if (b >= 8) rx = {rx[6:0], miso};
      else if (miso !== 1'b0) chk({tag, " R1 miso idle in command"}, {7'd0, miso}, 8'h00);
      sck = 1'b1;
      wait_clk(8);
    end
    wait_clk(6);
    csn = 1'b1;
    wait_clk(10);
    if (check) begin
      exp_q.push_back(exp);
      got_q.push_back(rx);
      tag_q.push_back(tag);
    end
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] d);
    xfer(addr & 8'hFE, d, 16, 1'b0, 8'h00, "");
  endtask

  task automatic rd(input logic [7:0] addr, input logic [7:0] exp, input string tag);
    xfer(addr | 8'h01, 8'h00, 16, 1'b1, exp, tag);
  endtask

  initial begin : monitor
    forever begin
      wait (got_q.size() > 0);
      chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R5 R8 reset state
    chk("R5 reset pwr_en", pwr_en, 8'h00);
    chk("R5 reset pmbus", pmbus, 8'h00);
    chk("R3 reset led", {4'h0, led}, 8'h00);
    chk("R8 reset irq", {7'd0, irq}, 8'h00);
    chk("R1 reset miso", {7'd0, miso}, 8'h00);

    // R1 R2 version read
    rd(8'h00, 8'h13, "R1 R2 version read");

    // R3 LED nibble
    wr(8'h02, 8'hAB);
    chk("R3 led_o upper nibble", {4'h0, led}, 8'h0A);
    rd(8'h02, 8'hA0, "R3 led readback low nibble zero");
    wr(8'h02, 8'h5F);
    chk("R3 led_o second write", {4'h0, led}, 8'h05);

    // R5 control registers
    wr(8'h0E, 8'h11); wr(8'h10, 8'h22); wr(8'h12, 8'h33); wr(8'h14, 8'h44);
    wr(8'h16, 8'h55); wr(8'h1A, 8'h66); wr(8'h1C, 8'h77); wr(8'h1E, 8'h88);
    chk("R5 pwr_en_o", pwr_en, 8'h11);
    chk("R5 cpu_rst_o", cpu_rst, 8'h22);
    chk("R5 usb_rst_o", usb_rst, 8'h33);
    chk("R5 sfpa_o", sfpa, 8'h44);
    chk("R5 sfpb_o", sfpb, 8'h55);
    chk("R5 warm_rst_o", warm_rst, 8'h66);
    chk("R5 warm_key_o", warm_key, 8'h77);
    chk("R5 pmbus_o", pmbus, 8'h88);
    rd(8'h10, 8'h22, "R5 cpu_rst readback");
    rd(8'h1E, 8'h88, "R5 pmbus readback");

    // R4 read-only registers ignore writes
    wr(8'h00, 8'hFF);
    rd(8'h00, 8'h13, "R4 version after write");
    wr(8'h18, 8'h00);
    rd(8'h18, 8'h81, "R4 i2c select after write");
    wr(8'h08, 8'h00);
    rd(8'h08, 8'h3C, "R4 power-good 1 after write");
    chk("R4 outputs untouched", pwr_en, 8'h11);

    // R6 live input reads
    rd(8'h0A, 8'hC3, "R6 power-good 2");
    rd(8'h0C, 8'h5A, "R6 power-good 3");
    pg2 = 8'h0F;
    wait_clk(6);
    rd(8'h0A, 8'h0F, "R6 power-good 2 live update");
    i2c = 8'h42;
    wait_clk(6);
    rd(8'h18, 8'h42, "R6 i2c select live update");

    // R7 R8 flags
    btn = 8'h08;
    wait_clk(6);
    chk("R8 irq on button edge", {7'd0, irq}, 8'h01);
    rd(8'h04, 8'h08, "R6 button level read");
    rd(8'h06, 8'h08, "R7 flag set on rise");
    btn = 8'h00;
    wait_clk(6);
    rd(8'h06, 8'h08, "R7 flag sticky after fall");
    btn = 8'h01;
    wait_clk(6);
    rd(8'h06, 8'h09, "R7 second flag");
    wr(8'h06, 8'h00);
    rd(8'h06, 8'h09, "R7 zero mask clears nothing");
    wr(8'h06, 8'h08);
    rd(8'h06, 8'h01, "R7 clear one bit");
    chk("R8 irq still set", {7'd0, irq}, 8'h01);
    wr(8'h06, 8'h01);
    rd(8'h06, 8'h00, "R7 all flags clear");
    chk("R8 irq low after clear", {7'd0, irq}, 8'h00);

    // R9 abort
    xfer(8'h0E, 8'hEE, 12, 1'b0, 8'h00, "");
    chk("R9 abort mid data byte", pwr_en, 8'h11);
    xfer(8'h02, 8'hF0, 5, 1'b0, 8'h00, "");
    chk("R9 abort mid command", {4'h0, led}, 8'h05);
    wr(8'h0E, 8'h99);
    chk("R9 clean transfer after abort", pwr_en, 8'h99);

    // R10 out of range
    rd(8'h20, 8'h00, "R10 read 0x20");
    rd(8'hFE, 8'h00, "R10 read 0xFE");
    wr(8'h20, 8'hFF);
    wr(8'h2E, 8'hFF);
    chk("R10 write 0x2E no pwr_en change", pwr_en, 8'h99);
    chk("R10 write 0x20 no led change", {4'h0, led}, 8'h05);
    rd(8'h0E, 8'h99, "R10 pwr_en readback intact");

    wait (got_q.size() == 0);
    wait_clk(4);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule